// File: doc/BRIEF.md
# Test Clock Pacer with Divider and Return-Clock Modes

This block produces the boundary-scan test clock (TCK) for a debug probe from a 60 MHz reference clock. A shift engine asks for one TCK period at a time with a single-cycle request. For each request the block drives TCK high and then low. It gives single-cycle strobes at the rising edge and at the falling edge so that the shifter can launch and capture data. It gives a completion strobe when the period is over. TCK rests low whenever no period is in progress.

There are two ways to time a period. In divider mode, the divisor input sets the TCK frequency to 60 MHz divided by an even divisor. Bit 0 of the divisor is discarded, and the width of the field limits the divisor to the range 2 to 8190. This gives 30 MHz at the fast end and about 7.3 kHz at the slow end. In adaptive mode, each half period ends only when the clock echoed back by the target, after a two-flop synchronizer, has followed TCK. If the echo does not follow within a fixed window, a sticky error flag is raised and the period completes anyway. The flag stays set until it is cleared with a write-one pulse. This lets software discard false alarms, such as those caused by the target's test reset stopping its echo.

Top module: `tck_pacer`

## Requirements
- R1: After reset, `tck`, `rise_stb`, `fall_stb`, `cyc_done` and `timeout_err` are all 0.
- R2: In divider mode, the half-period length is H = `div_cfg[12:1]` reference cycles, and bit 0 of `div_cfg` has no effect. When H would be 0 (`div_cfg` is 0 or 1), H is 1, so the divisor is 2.
- R3: The largest divisor is 8190 (`div_cfg` = 8191 or 8190, which gives H = 4095 high cycles and 4095 low cycles).
- R4: `rise_stb` is high for exactly one cycle, in the first cycle that `tck` is high. `fall_stb` is high for exactly one cycle, in the first cycle that `tck` is low. `cyc_done` is high for one cycle, directly after the low phase.
- R5: When no period is requested, `tck` stays low. A request is accepted while idle, or in the cycle that `cyc_done` is raised.
- R6: In adaptive mode, `tck` stays high until the synchronized `rtck_in` is high. It then goes low and stays low until the synchronized `rtck_in` is low. With `rtck_in` following `tck` after D reference cycles, each phase lasts D+3 cycles.
- R7: In adaptive mode, a phase that has no response after 4096 reference cycles ends anyway and sets `timeout_err`.
- R8: `timeout_err` stays at 1 until a cycle with `err_clr` = 1 clears it. When a new timeout and `err_clr` occur in the same cycle, the new timeout wins.
- R9: Divider mode ignores `rtck_in` and never sets `timeout_err`.
- R10: The mode and the divisor are captured when the request is accepted. Changes to them during a period do not affect that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | 13 | Divisor value; bit 0 is ignored |
| adaptive_en | input | 1 | 1 selects return-clock pacing |
| cyc_req | input | 1 | Request for one TCK period |
| rtck_in | input | 1 | Clock echoed back by the target (asynchronous) |
| err_clr | input | 1 | Write-one pulse that clears the timeout flag |
| tck | output | 1 | Test clock |
| rise_stb | output | 1 | Pulse in the first high cycle of `tck` |
| fall_stb | output | 1 | Pulse in the first low cycle of `tck` |
| cyc_done | output | 1 | Pulse after the end of a period |
| timeout_err | output | 1 | Sticky flag for an adaptive-mode timeout |

## Verification
The hardest cases to reach are the adaptive-mode timeouts. They need an echo that stays silent for 4096 cycles in one specific phase: stuck low to time out the high phase, and stuck high to time out the low phase. The bench models the target's echo as a settable delay line fed by `tck`, and it can also force the echo to a constant 0 or 1. This reaches both timeout paths, and also the same-cycle race between a new timeout and `err_clr`. Each period also changes the divisor and the mode right after its request, to show that the values captured at acceptance are the ones in use.

// File: rtl/tckp_pkg.sv
package tckp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;
endpackage

// File: rtl/tckp_sync.sv
module tckp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tckp_half_calc.sv
module tckp_half_calc #(
  parameter int DIV_W  = 13,
  localparam int HALF_W = DIV_W - 1
) (
  input  logic [DIV_W-1:0]  div_cfg,
  output logic [HALF_W-1:0] half_len
);
  logic [HALF_W-1:0] raw_half;

  always_comb begin
    raw_half = div_cfg[DIV_W-1:1];
    if (raw_half == '0) half_len = HALF_W'(1);
    else                half_len = raw_half;
  end
endmodule

// File: rtl/tckp_down_cnt.sv
module tckp_down_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? load_val : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !zero);
endmodule

// File: rtl/tck_pacer.sv
module tck_pacer #(
  parameter int DIV_W       = 13,
  parameter int TMO_CYCLES  = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             adaptive_en,
  input  logic             cyc_req,
  input  logic             rtck_in,
  input  logic             err_clr,
  output logic             tck,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             cyc_done,
  output logic             timeout_err
);
  import tckp_pkg::*;

  localparam int HALF_W = DIV_W - 1;
  localparam int TMO_W  = $clog2(TMO_CYCLES);
  localparam int CNT_W  = (HALF_W > TMO_W) ? HALF_W : TMO_W;
  localparam logic [CNT_W-1:0] TMO_LOAD = CNT_W'(TMO_CYCLES - 1);

  phase_e            phase_q, phase_d;
  logic              tck_q, tck_d;
  logic              rise_q, rise_d;
  logic              fall_q, fall_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              adapt_q, adapt_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic [HALF_W-1:0] half_now;
  logic              rt_s;
  logic              cnt_zero, cnt_load, cnt_dec;
  logic [CNT_W-1:0]  cnt_val;
  logic              start, set_err;

  tckp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rtck_in), .q(rt_s)
  );

  tckp_half_calc #(.DIV_W(DIV_W)) u_half (
    .div_cfg(div_cfg), .half_len(half_now)
  );

  tckp_down_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .zero(cnt_zero)
  );

  // next-state logic
  always_comb begin
    phase_d  = phase_q;
    tck_d    = tck_q;
    rise_d   = 1'b0;
    fall_d   = 1'b0;
    done_d   = 1'b0;
    adapt_d  = adapt_q;
    half_d   = half_q;
    set_err  = 1'b0;
    start    = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    cnt_val  = adapt_q ? TMO_LOAD : CNT_W'(half_q - HALF_W'(1));

    unique case (phase_q)
      PH_IDLE: begin
        if (cyc_req) start = 1'b1;
      end
      PH_HIGH: begin
        if (adapt_q ? (rt_s || cnt_zero) : cnt_zero) begin
          phase_d  = PH_LOW;
          tck_d    = 1'b0;
          fall_d   = 1'b1;
          cnt_load = 1'b1;
          set_err  = adapt_q && !rt_s;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      PH_LOW: begin
        if (adapt_q ? (!rt_s || cnt_zero) : cnt_zero) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
          set_err = adapt_q && rt_s;
          if (cyc_req) start = 1'b1;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase

    if (start) begin
      phase_d  = PH_HIGH;
      tck_d    = 1'b1;
      rise_d   = 1'b1;
      adapt_d  = adaptive_en;
      half_d   = half_now;
      cnt_load = 1'b1;
      cnt_dec  = 1'b0;
      cnt_val  = adaptive_en ? TMO_LOAD : CNT_W'(half_now - HALF_W'(1));
    end

    if (set_err)      err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
    else              err_d = err_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tck_q   <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      adapt_q <= 1'b0;
      half_q  <= HALF_W'(1);
    end else begin
      phase_q <= phase_d;
      tck_q   <= tck_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      done_q  <= done_d;
      err_q   <= err_d;
      adapt_q <= adapt_d;
      half_q  <= half_d;
    end
  end

  assign tck         = tck_q;
  assign rise_stb    = rise_q;
  assign fall_stb    = fall_q;
  assign cyc_done    = done_q;
  assign timeout_err = err_q;

  // R4
  rise_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> rise_stb);
  // R4
  fall_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tck) |-> fall_stb);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb}));
  // R5
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && !cyc_req) |=> !tck);
  // R8
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_err && !err_clr) |=> timeout_err);
  // R9
  div_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!timeout_err && !adapt_q && phase_q != PH_IDLE) |=> !timeout_err);
endmodule

// File: tb/tck_pacer_test.sv
module tck_pacer_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 4096;

  logic        clk, rst_n;
  logic [12:0] div_cfg;
  logic        adaptive_en, cyc_req, rtck_in, err_clr;
  logic        tck, rise_stb, fall_stb, cyc_done, timeout_err;

  int errors = 0;
  int checks = 0;

  // echo model: 0 = constant low, 1 = constant high, 2 = delayed copy of tck
  int        echo_mode = 0;
  int        echo_dly  = 1;
  logic [3:0] echo_sh;

  tck_pacer uut (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .adaptive_en(adaptive_en),
    .cyc_req(cyc_req), .rtck_in(rtck_in), .err_clr(err_clr), .tck(tck),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .cyc_done(cyc_done),
    .timeout_err(timeout_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) echo_sh <= {echo_sh[2:0], tck};

  always_comb begin
    if (echo_mode == 0)      rtck_in = 1'b0;
    else if (echo_mode == 1) rtck_in = 1'b1;
    else                     rtck_in = echo_sh[echo_dly-1];
  end

  function automatic int exp_half(input logic [12:0] d);
    int h;
    h = int'(d >> 1);
    if (h == 0) h = 1;
    return h;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cycle(input logic [12:0] d, input bit adp,
                           output int hi, output int lo,
                           output int rises, output int falls);
    int guard;
    hi = 0; lo = 0; rises = 0; falls = 0; guard = 0;
    @(negedge clk);
    div_cfg = d; adaptive_en = adp; cyc_req = 1'b1;
    @(negedge clk);
    cyc_req = 1'b0;
    div_cfg = 13'($urandom);         // R10: changed during the period
    adaptive_en = ~adp;
    while (!cyc_done && guard < 20000) begin
      if (tck) hi++; else lo++;
      rises += int'(rise_stb);
      falls += int'(fall_stb);
      guard++;
      @(negedge clk);
    end
    chk(guard < 20000, "R4 done seen", guard, 0);
    adaptive_en = adp;
    @(negedge clk);
    chk(!cyc_done, "R4 done one cycle", int'(cyc_done), 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hi, lo, rs, fs, h;
    logic [12:0] d;
    void'($urandom(32'd1234));
    rst_n = 1'b0; div_cfg = '0; adaptive_en = 1'b0; cyc_req = 1'b0; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(!tck && !rise_stb && !fall_stb && !cyc_done && !timeout_err, "R1 reset outputs",
        int'({tck, rise_stb, fall_stb, cyc_done, timeout_err}), 0);
    rst_n = 1'b1;

    // R5: idle with no request
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i % 5 == 0) chk(!tck, "R5 idle low", int'(tck), 0);
    end

    // R2: directed small divisors and odd values
    for (int v = 0; v < 8; v++) begin
      d = 13'(v);
      run_cycle(d, 1'b0, hi, lo, rs, fs);
      h = exp_half(d);
      chk(hi == h, "R2 high len", hi, h);
      chk(lo == h, "R2 low len", lo, h);
      chk(rs == 1 && fs == 1, "R4 one strobe each", rs * 10 + fs, 11);
    end

    // R3: top of the range
    run_cycle(13'd8191, 1'b0, hi, lo, rs, fs);
    chk(hi == 4095 && lo == 4095, "R3 max divisor odd", hi + lo, 8190);
    run_cycle(13'd8190, 1'b0, hi, lo, rs, fs);
    chk(hi == 4095 && lo == 4095, "R3 max divisor even", hi + lo, 8190);

    // R2/R9/R10: random divisors, echo silent in divider mode
    echo_mode = 0;
    for (int n = 0; n < 30; n++) begin
      if (n % 10 == 9) d = 13'($urandom);
      else             d = 13'($urandom % 64);
      run_cycle(d, 1'b0, hi, lo, rs, fs);
      h = exp_half(d);
      chk(hi == h && lo == h, "R2 R10 random divisor", hi * 10000 + lo, h * 10000 + h);
      chk(!timeout_err, "R9 no error in divider mode", int'(timeout_err), 0);
    end

    // R6: adaptive with echo delays 1..4
    echo_mode = 2;
    for (int n = 0; n < 12; n++) begin
      echo_dly = 1 + int'($urandom % 4);
      run_cycle(13'($urandom), 1'b1, hi, lo, rs, fs);
      chk(hi == echo_dly + 3 && lo == echo_dly + 3, "R6 adaptive phases",
          hi * 100 + lo, (echo_dly + 3) * 101);
      chk(rs == 1 && fs == 1, "R4 adaptive strobes", rs * 10 + fs, 11);
      chk(!timeout_err, "R6 no timeout with echo", int'(timeout_err), 0);
    end

    // R7: echo stuck low, high phase times out
    echo_mode = 0;
    run_cycle(13'd2, 1'b1, hi, lo, rs, fs);
    chk(hi == TMO, "R7 high timeout length", hi, TMO);
    chk(lo == 1, "R7 low ends on low echo", lo, 1);
    chk(timeout_err, "R7 flag set", int'(timeout_err), 1);

    // R8: sticky across a divider cycle
    run_cycle(13'd4, 1'b0, hi, lo, rs, fs);
    chk(timeout_err, "R8 flag sticky", int'(timeout_err), 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    chk(!timeout_err, "R8 flag cleared", int'(timeout_err), 0);

    // R7: echo stuck high, low phase times out
    echo_mode = 1;
    repeat (4) @(negedge clk);
    run_cycle(13'd2, 1'b1, hi, lo, rs, fs);
    chk(hi == 1, "R7 high ends on high echo", hi, 1);
    chk(lo == TMO, "R7 low timeout length", lo, TMO);
    chk(timeout_err, "R7 flag set low phase", int'(timeout_err), 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    echo_mode = 0;
    repeat (4) @(negedge clk);
    chk(!timeout_err, "R8 clear again", int'(timeout_err), 0);

    // R8: timeout and clear in the same cycle; set wins
    @(negedge clk);
    div_cfg = 13'd2; adaptive_en = 1'b1; cyc_req = 1'b1;
    @(negedge clk);
    cyc_req = 1'b0;
    repeat (TMO - 1) @(negedge clk);
    chk(!timeout_err, "R7 not before window", int'(timeout_err), 0);
    err_clr = 1'b1;   // held across the timeout edge
    @(negedge clk);
    err_clr = 1'b0;
    chk(timeout_err && fall_stb, "R8 set beats clear",
        int'({timeout_err, fall_stb}), 3);
    repeat (6) @(negedge clk);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    chk(!timeout_err, "R8 final clear", int'(timeout_err), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule